// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which DMA channel may use the shared transfer engine next. Each channel gathers a small group of peripheral request lines into one channel request, and that request counts only while the channel's enable bit is set. Each channel also carries a two-bit software level. Whenever the engine is free, the arbiter picks one requesting channel. The software level is compared first. When levels are equal, the channel with the lower number wins.

The chosen channel keeps its grant until the engine reports, on a one-cycle done strobe, that the single transfer has finished. The grant then drops for one cycle and the next decision is taken on the clock edge after that. The outputs are a one-hot grant vector, the binary index of the granted channel, and a valid flag. The channel count and the number of request lines per channel are parameters. The full controller uses seven channels and the smaller one uses five.

Top module: `dma_channel_arbiter`

## Requirements
- R1: Channel c requests only when `chan_en[c]` is 1 and at least one of its lines `chan_lines[c*LINES_PER_CH +: LINES_PER_CH]` is 1. A disabled channel is never granted, whatever its lines or level show.
- R2: The level of channel c is `chan_level[2*c +: 2]`, where 0 is low, 1 is medium, 2 is high and 3 is very high. A requesting channel with a higher level beats every channel with a lower level, whatever the channel numbers.
- R3: Among requesting channels that share the top level, the lowest-numbered channel is granted.
- R4: When no grant is held and at least one channel requests at a rising edge, the grant outputs show the winner from that edge on.
- R5: While `grant_valid` is 1, `grant_vec` has exactly one bit set, and that bit is bit number `grant_idx`.
- R6: While a grant is held and `xfer_done` is 0, the grant outputs do not change, even when requests, enables or levels change.
- R7: A rising edge with `xfer_done` at 1 during a held grant clears the grant, so that `grant_valid` is 0 for the following cycle even when requests are pending. Arbitration happens at the next edge.
- R8: When nothing is granted, `grant_vec` is all zeros, `grant_idx` is 0 and `grant_valid` is 0.
- R9: A rising edge with `rst_n` at 0 clears all grant outputs, whatever the inputs show.
- R10: `xfer_done` at 1 while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | NUM_CH | Per-channel enable |
| chan_lines | input | NUM_CH*LINES_PER_CH | Peripheral request lines, grouped per channel |
| chan_level | input | 2*NUM_CH | Two-bit software level per channel |
| xfer_done | input | 1 | One-cycle strobe marking the end of the granted transfer |
| grant_vec | output | NUM_CH | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted channel |
| grant_valid | output | 1 | A grant is held |

## Verification
The bench sets up several conflicts. In one, a low-numbered channel at low level faces a high-numbered channel at very high level. A design that uses channel order first would grant the wrong channel. In another, several channels tie at the same level, and a design with a reversed tie-break would pick the highest number. A disabled channel with active lines and the top level is placed beside an enabled low-level channel, to catch a gate that ignores the enable. After the grant, the bench raises a higher-priority request and drops the winner's own request. A design that re-arbitrates without waiting for done would move the grant. The bench also pulses done with requests still pending and expects one empty cycle before the new grant. A design that chains grants back to back, or that reacts to a done strobe while idle, is caught by the outputs in that cycle.

// File: rtl/dma_arb_pkg.sv
// Package: shared types and helpers for the DMA channel arbiter.
// Assumes software levels are two bits wide, with a larger value meaning more urgent.
package dma_arb_pkg;

    localparam int LEVEL_W = 2;

    typedef logic [LEVEL_W-1:0] level_t;

    localparam level_t LEVEL_LOW       = 2'd0;
    localparam level_t LEVEL_MEDIUM    = 2'd1;
    localparam level_t LEVEL_HIGH      = 2'd2;
    localparam level_t LEVEL_VERY_HIGH = 2'd3;

    // Width of a binary channel index. It is never zero, even for a single channel.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_req_merge.sv
// Request merge: folds each channel's group of peripheral lines into one
// request bit and gates that bit with the channel enable.
// Assumes the lines of channel c occupy chan_lines[c*LINES_PER_CH +: LINES_PER_CH].
module dma_req_merge #(
    parameter int NUM_CH       = 7,
    parameter int LINES_PER_CH = 4
) (
    input  logic [NUM_CH-1:0]              chan_en,
    input  logic [NUM_CH*LINES_PER_CH-1:0] chan_lines,
    output logic [NUM_CH-1:0]              chan_req
);

    // One OR-and-gate per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_merge
        assign chan_req[g] = chan_en[g] & (|chan_lines[g*LINES_PER_CH +: LINES_PER_CH]);
    end

endmodule

// File: rtl/dma_prio_select.sv
// Two-tier selector, purely combinational. It first finds the highest software
// level among the requesting channels. Within that level it picks the lowest channel number.
// Assumes the level of channel c sits at chan_level[c*LEVEL_W +: LEVEL_W].
module dma_prio_select
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CH-1:0]         chan_req,
    input  logic [NUM_CH*LEVEL_W-1:0] chan_level,
    output logic [NUM_CH-1:0]         pick_vec,
    output logic [IDX_W-1:0]          pick_idx,
    output logic                      pick_any
);

    level_t lvl_arr [NUM_CH];
    level_t top_lvl;
    logic   found;

    // Split the flat level bus into one field per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
        assign lvl_arr[g] = chan_level[g*LEVEL_W +: LEVEL_W];
    end

    // Tier one: find the highest level held by any requesting channel.
    always_comb begin
        top_lvl = LEVEL_LOW;
        found   = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_req[c] && (!found || (lvl_arr[c] > top_lvl))) begin
                top_lvl = lvl_arr[c];
                found   = 1'b1;
            end
        end
    end

    // Tier two: the scan runs downward, so the last match is the lowest channel number at the top level.
    always_comb begin
        pick_vec = '0;
        pick_idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (chan_req[c] && (lvl_arr[c] == top_lvl)) begin
                pick_vec    = '0;
                pick_vec[c] = 1'b1;
                pick_idx    = IDX_W'(c);
            end
        end
    end

    assign pick_any = found;

endmodule

// File: rtl/dma_grant_hold.sv
// Grant register: loads the selector's choice while idle and keeps it until
// the done strobe. The release cycle is always followed by one idle cycle.
// Assumes xfer_done is meaningful only while a grant is held.
module dma_grant_hold #(
    parameter int NUM_CH = 7,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pick_vec,
    input  logic [IDX_W-1:0]  pick_idx,
    input  logic              pick_any,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] grant_vec,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_valid
);

    // Load when idle, hold while busy, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vec   <= '0;
            grant_idx   <= '0;
            grant_valid <= 1'b0;
        end else if (grant_valid) begin
            if (xfer_done) begin
                grant_vec   <= '0;
                grant_idx   <= '0;
                grant_valid <= 1'b0;
            end
        end else if (pick_any) begin
            grant_vec   <= pick_vec;
            grant_idx   <= pick_idx;
            grant_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_channel_arbiter.sv
// Top level of the DMA channel arbiter: request merge, then two-tier
// selection, then the grant register.
// Assumes one transfer per grant, ended by a single-cycle xfer_done strobe.
module dma_channel_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH       = 7,
    parameter int LINES_PER_CH = 4,
    localparam int IDX_W       = idx_width(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              chan_en,
    input  logic [NUM_CH*LINES_PER_CH-1:0] chan_lines,
    input  logic [NUM_CH*LEVEL_W-1:0]      chan_level,
    input  logic                           xfer_done,
    output logic [NUM_CH-1:0]              grant_vec,
    output logic [IDX_W-1:0]               grant_idx,
    output logic                           grant_valid
);

    logic [NUM_CH-1:0] chan_req;
    logic [NUM_CH-1:0] pick_vec;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;

    dma_req_merge #(
        .NUM_CH      (NUM_CH),
        .LINES_PER_CH(LINES_PER_CH)
    ) u_merge (
        .chan_en   (chan_en),
        .chan_lines(chan_lines),
        .chan_req  (chan_req)
    );

    dma_prio_select #(
        .NUM_CH(NUM_CH),
        .IDX_W (IDX_W)
    ) u_select (
        .chan_req  (chan_req),
        .chan_level(chan_level),
        .pick_vec  (pick_vec),
        .pick_idx  (pick_idx),
        .pick_any  (pick_any)
    );

    dma_grant_hold #(
        .NUM_CH(NUM_CH),
        .IDX_W (IDX_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_vec   (pick_vec),
        .pick_idx   (pick_idx),
        .pick_any   (pick_any),
        .xfer_done  (xfer_done),
        .grant_vec  (grant_vec),
        .grant_idx  (grant_idx),
        .grant_valid(grant_valid)
    );

endmodule

// File: rtl/dma_channel_arbiter_chk.sv
// Checker: temporal properties of the grant outputs, measured against the
// merged channel requests. It is attached to every arbiter instance by bind.
module dma_channel_arbiter_chk #(
    parameter int NUM_CH = 7,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] eff_req,
    input logic              xfer_done,
    input logic [NUM_CH-1:0] grant_vec,
    input logic [IDX_W-1:0]  grant_idx,
    input logic              grant_valid
);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant_vec) == 1));

    assert_idx_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_vec[grant_idx]);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_vec == '0 && grant_idx == '0));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_vec) && $stable(grant_idx)));

    assert_release_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);

    assert_arbitrate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (|eff_req)) |=> grant_valid);

    assert_no_phantom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !(|eff_req)) |=> !grant_valid);

    assert_grant_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (|eff_req)) |=> (|(grant_vec & $past(eff_req))));

endmodule

bind dma_channel_arbiter dma_channel_arbiter_chk #(
    .NUM_CH(NUM_CH),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_req    (chan_req),
    .xfer_done  (xfer_done),
    .grant_vec  (grant_vec),
    .grant_idx  (grant_idx),
    .grant_valid(grant_valid)
);

// File: tb/dma_channel_arbiter_test.sv
// Scoreboard bench. The step task drives one cycle of inputs on a falling
// edge and queues the outputs expected after the next rising edge. The monitor
// compares them on the falling edge that follows.
module dma_channel_arbiter_test;

    localparam int NCH = 7;
    localparam int NL  = 4;
    localparam int IW  = 3;

    typedef struct {
        int    due;
        bit    exp_v;
        int    exp_i;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    chan_en = '0;
    logic [NCH*NL-1:0] chan_lines = '0;
    logic [2*NCH-1:0]  chan_level = '0;
    logic              xfer_done = 1'b0;
    logic [NCH-1:0]    grant_vec;
    logic [IW-1:0]     grant_idx;
    logic              grant_valid;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    dma_channel_arbiter #(.NUM_CH(NCH), .LINES_PER_CH(NL)) uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_lines(chan_lines),
        .chan_level(chan_level), .xfer_done(xfer_done),
        .grant_vec(grant_vec), .grant_idx(grant_idx), .grant_valid(grant_valid)
    );

    always #10 clk = ~clk;

    // Cycle counter, used to match queued expectations to the cycle they are due.
    always @(posedge clk) cyc <= cyc + 1;

    // Request line j of channel c.
    function automatic logic [NCH*NL-1:0] ln(input int c, input int j);
        return (NCH*NL)'(1) << (c*NL + j);
    endfunction

    // Level field v placed at channel c.
    function automatic logic [2*NCH-1:0] lv(input int c, input int v);
        return (2*NCH)'(v) << (2*c);
    endfunction

    // Driver: apply one cycle of inputs and queue the expected grant.
    task automatic step(input logic [NCH-1:0] en, input logic [NCH*NL-1:0] rq,
                        input logic [2*NCH-1:0] lvl, input logic dn,
                        input bit ev, input int ei, input string tag);
        exp_t e;
        @(negedge clk);
        chan_en = en; chan_lines = rq; chan_level = lvl; xfer_done = dn;
        e.due = cyc + 1; e.exp_v = ev; e.exp_i = ei; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare the outputs against each item due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic [NCH-1:0] exp_vec;
            e = sb.pop_front();
            exp_vec = e.exp_v ? (NCH'(1) << e.exp_i) : '0;
            checks++;
            if (grant_valid !== e.exp_v || grant_vec !== exp_vec
                || grant_idx !== IW'(e.exp_v ? e.exp_i : 0)) begin
                failures++;
                $display("FAIL %s: actual valid=%0b vec=%b idx=%0d expected valid=%0b vec=%b idx=%0d",
                         e.tag, grant_valid, grant_vec, grant_idx, e.exp_v, exp_vec,
                         e.exp_v ? e.exp_i : 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL R4: actual=hung expected=run completes");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        // R9: reset dominates active requests.
        step('1, '1, '1, 1'b0, 0, 0, "R9 reset with requests");
        step('1, '1, '1, 1'b1, 0, 0, "R9 reset with done");
        step('0, '0, '0, 1'b0, 0, 0, "R9 reset idle");
        rst_n = 1'b1;
        // R8: no requests.
        step('0, '0, '0, 1'b0, 0, 0, "R8 idle after reset");
        // R1 and R10: disabled channel with lines up, and a done strobe while idle.
        step(7'b1111011, ln(2,0)|ln(2,1)|ln(2,2)|ln(2,3), lv(2,3), 1'b1, 0, 0,
             "R1 R10 disabled channel and idle done");
        // R4: single request on line 2 of channel 3.
        step('1, ln(3,2), '0, 1'b0, 1, 3, "R4 single request granted");
        // R6: a higher-priority newcomer does not preempt.
        step('1, ln(3,2)|ln(0,0), lv(0,3), 1'b0, 1, 3, "R6 hold against newcomer");
        step('1, ln(0,0), lv(0,3), 1'b0, 1, 3, "R6 hold after own request drops");
        // R7: release leaves a gap, then re-arbitration.
        step('1, ln(0,0), lv(0,3), 1'b1, 0, 0, "R7 release gap");
        step('1, ln(0,0), lv(0,3), 1'b0, 1, 0, "R7 re-arbitration");
        step('1, '0, '0, 1'b1, 0, 0, "R7 release to idle");
        // R2: a high level beats a low channel number.
        step('1, ln(6,1)|ln(1,3)|ln(0,0), lv(6,3)|lv(1,1), 1'b0, 1, 6, "R2 very high level wins");
        step('1, ln(1,3)|ln(0,0), lv(6,3)|lv(1,1), 1'b1, 0, 0, "R7 release");
        step('1, ln(1,3)|ln(0,0), lv(6,3)|lv(1,1), 1'b0, 1, 1, "R2 medium beats low");
        step('1, '0, '0, 1'b1, 0, 0, "R7 release");
        // R3: three-way tie at the high level.
        step('1, ln(4,0)|ln(2,3)|ln(5,2), lv(4,2)|lv(2,2)|lv(5,2), 1'b0, 1, 2, "R3 tie picks lowest");
        step('1, ln(4,0)|ln(5,2), lv(4,2)|lv(2,2)|lv(5,2), 1'b1, 0, 0, "R7 release");
        step('1, ln(4,0)|ln(5,2), lv(4,2)|lv(2,2)|lv(5,2), 1'b0, 1, 4, "R3 next lowest in tie");
        step('1, '0, '0, 1'b1, 0, 0, "R7 release");
        // R3: every channel requests at the very high level.
        step('1, '1, '1, 1'b0, 1, 0, "R3 all channels tie");
        step('1, '0, '0, 1'b1, 0, 0, "R7 release");
        // R1: a disabled very-high channel loses to an enabled low channel.
        step(7'b0111111, ln(6,0)|ln(5,1), lv(6,3), 1'b0, 1, 5, "R1 disabled level ignored");
        step('1, '0, '0, 1'b1, 0, 0, "R7 release");
        step('1, '0, '0, 1'b0, 0, 0, "R8 idle at end");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule